// File: doc/BRIEF.md
# Serial-Loaded Latched LED Channel Controller

This block drives a row of LED sink enables from a serial stream. Each rising edge of a slow serial clock moves the serial data one place along a channel-wide shift register. A latch-control input copies the register into the channel latches. The last stage of the register also drives a serial output, so several controllers can be chained on one data line. Two gating inputs switch every channel off without touching any stored data: an active-high blank input and an over-voltage fault flag.

The serial clock, serial data, latch, blank and fault inputs are all asynchronous to the system clock. Each one goes through a two-flop synchronizer. The shift logic acts on a rising edge of the synchronized serial clock, found by edge detection, so the system clock must oversample the serial clock. Outputs are active-high sink-enable bits, one for each channel.

Top module: `led_chain_ctrl`

## Requirements
- R1: Each rising edge of `ser_clk`, after synchronization, moves the shift register forward by exactly one stage and captures the `ser_din` value present at that edge. Between rising edges the register does not move.
- R2: After a full load of NUM_CH bits, the bit shifted in last sets channel 0 (`chan_on[0]`) and the bit shifted in first sets channel NUM_CH-1. Bit i of a load pattern maps to `chan_on[i]`, so the pattern is shifted in from bit NUM_CH-1 down to bit 0.
- R3: `ser_dout` is the last shift stage, which is the bit that sets channel NUM_CH-1. After k further shifts it presents bit NUM_CH-1-k of the previous contents. It changes only after a shift edge.
- R4: While `latch_en` is low the channel latches hold their values. While it is high the latches take the shift register contents.
- R5: While `blank` is high every `chan_on` bit is 0. The latched pattern returns once `blank` goes low.
- R6: While `fault_ov` is high every `chan_on` bit is 0. The latched pattern returns by itself once the fault clears.
- R7: Reset clears the shift register, so `ser_dout` stays 0 until NUM_CH new bits have been shifted in.
- R8: Reset clears the channel latches, so every `chan_on` bit is 0 after reset.
- R9: Neither blanking nor the fault changes the shift register or the latches. A channel is on only when its latched bit is 1, `blank` is low and `fault_ov` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples `ser_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; the block acts on its rising edges |
| ser_din | input | 1 | Serial data input |
| latch_en | input | 1 | Latch control; high copies the shift register into the channel latches |
| blank | input | 1 | Active-high blank; forces all channels off |
| fault_ov | input | 1 | Over-voltage fault flag; forces all channels off |
| ser_dout | output | 1 | Serial output from the last shift stage |
| chan_on | output | NUM_CH | Sink enable for each channel, active high |

## Verification
The assertions assume that every control input stays stable long enough for the synchronizers to capture it. They also assume that `ser_din` is settled before `ser_clk` rises, because both pass through synchronizers of the same depth and are then sampled together. The stimulus holds every input level for four system clocks before and after each serial-clock transition, and it changes data only while `ser_clk` is low. This keeps the input setup well inside the assumed window. Blank and fault are raised and lowered only at the same phase boundaries, so the gating checks never observe a half-synchronized level.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;
   localparam int unsigned DEF_CHANNELS    = 10;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Bit positions of the inputs inside the synchronizer bundle.
   localparam int unsigned IDX_SCLK  = 0;
   localparam int unsigned IDX_DIN   = 1;
   localparam int unsigned IDX_LATCH = 2;
   localparam int unsigned IDX_BLANK = 3;
   localparam int unsigned IDX_FAULT = 4;
   localparam int unsigned SYNC_W    = 5;
endpackage

// File: rtl/led_sync.sv
module led_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("led_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/led_shift.sv
module led_shift #(
   parameter int unsigned N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_s,
   input  logic         din_s,
   output logic         rise,
   output logic [N-1:0] sreg
);
   logic sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_prev;

   // Newest bit enters stage 0; the oldest sits in stage N-1.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sreg <= '0;
      else if (rise) sreg <= {sreg[N-2:0], din_s};
   end
endmodule

// File: rtl/led_gate.sv
module led_gate #(
   parameter int unsigned N = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] sreg,
   input  logic         blank_s,
   input  logic         fault_s,
   output logic [N-1:0] latch_q,
   output logic [N-1:0] chan_on
);
   logic enable;
   assign enable = ~blank_s & ~fault_s;

   generate
      for (genvar c = 0; c < N; c++) begin : g_chan
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    latch_q[c] <= 1'b0;
            else if (load) latch_q[c] <= sreg[c];
         end
         assign chan_on[c] = latch_q[c] & enable;
      end
   endgenerate
endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
   import led_chain_pkg::*;
#(
   parameter int unsigned NUM_CH      = DEF_CHANNELS,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              latch_en,
   input  logic              blank,
   input  logic              fault_ov,
   output logic              ser_dout,
   output logic [NUM_CH-1:0] chan_on
);
   generate
      if (NUM_CH < 2) begin : g_bad_width
         $error("led_chain_ctrl: NUM_CH must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] syn_in;
   logic              sclk_s, din_s, latch_s, blank_s, fault_s;
   logic              sh_rise;
   logic [NUM_CH-1:0] sreg_q;
   logic [NUM_CH-1:0] latch_q;

   always_comb begin
      raw_in            = '0;
      raw_in[IDX_SCLK]  = ser_clk;
      raw_in[IDX_DIN]   = ser_din;
      raw_in[IDX_LATCH] = latch_en;
      raw_in[IDX_BLANK] = blank;
      raw_in[IDX_FAULT] = fault_ov;
   end

   led_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign sclk_s  = syn_in[IDX_SCLK];
   assign din_s   = syn_in[IDX_DIN];
   assign latch_s = syn_in[IDX_LATCH];
   assign blank_s = syn_in[IDX_BLANK];
   assign fault_s = syn_in[IDX_FAULT];

   led_shift #(.N(NUM_CH)) shift_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (sclk_s),
      .din_s  (din_s),
      .rise   (sh_rise),
      .sreg   (sreg_q)
   );

   assign ser_dout = sreg_q[NUM_CH-1];

   led_gate #(.N(NUM_CH)) gate_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (latch_s),
      .sreg    (sreg_q),
      .blank_s (blank_s),
      .fault_s (fault_s),
      .latch_q (latch_q),
      .chan_on (chan_on)
   );
endmodule

// File: rtl/led_chain_chk.sv
module led_chain_chk #(
   parameter int unsigned N = 10
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rise,
   input logic         din_s,
   input logic [N-1:0] sreg,
   input logic         latch_s,
   input logic [N-1:0] latch_q,
   input logic         blank_s,
   input logic         fault_s,
   input logic [N-1:0] chan_on,
   input logic         ser_dout
);
   // R1: one stage per detected edge
   p_shift_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> sreg == {$past(sreg[N-2:0]), $past(din_s)});

   // R1: no movement without an edge
   p_shift_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(sreg));

   // R3: serial output changes only after a shift edge
   p_dout_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(ser_dout));

   // R4: latches hold while latch control is low
   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_s |=> $stable(latch_q));

   // R4: latches take the register while latch control is high
   p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      latch_s |=> latch_q == $past(sreg));

   // R5: blank forces all channels off
   p_blank_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blank_s |-> chan_on == '0);

   // R6: fault forces all channels off
   p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_s |-> chan_on == '0);

   // R9: gating alone leaves the latches untouched
   p_gate_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_s && (blank_s || fault_s)) |=> latch_q == $past(latch_q));
endmodule

bind led_chain_ctrl led_chain_chk #(.N(NUM_CH)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rise     (sh_rise),
   .din_s    (din_s),
   .sreg     (sreg_q),
   .latch_s  (latch_s),
   .latch_q  (latch_q),
   .blank_s  (blank_s),
   .fault_s  (fault_s),
   .chan_on  (chan_on),
   .ser_dout (ser_dout)
);

// File: tb/led_chain_ctrl_tb_top.sv
`timescale 1ns/1ps
module led_chain_ctrl_tb_top;
   localparam int N = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_clk = 1'b0, ser_din = 1'b0, latch_en = 1'b0;
   logic         blank = 1'b0, fault_ov = 1'b0;
   logic         ser_dout;
   logic [N-1:0] chan_on;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   led_chain_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .latch_en(latch_en), .blank(blank), .fault_ov(fault_ov),
      .ser_dout(ser_dout), .chan_on(chan_on)
   );

   // Vector: {pattern, blank, fault, expected chan_on}
   localparam logic [21:0] VEC [5] = '{
      {10'h2A5, 1'b0, 1'b0, 10'h2A5},
      {10'h3FF, 1'b1, 1'b0, 10'h000},
      {10'h155, 1'b0, 1'b1, 10'h000},
      {10'h001, 1'b0, 1'b0, 10'h001},
      {10'h200, 1'b1, 1'b1, 10'h000}
   };

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      ser_din = b;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
   endtask

   task automatic shift_word(input logic [N-1:0] w);
      for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
   endtask

   task automatic pulse_latch();
      latch_en = 1'b1;
      wait_clk(4);
      latch_en = 1'b0;
      wait_clk(4);
   endtask

   task automatic check_ch(input string req, input logic [N-1:0] exp);
      checks++;
      if (chan_on !== exp) begin
         errors++;
         $display("FAIL %s chan_on actual=%h expected=%h", req, chan_on, exp);
      end
   endtask

   task automatic check_do(input string req, input logic exp);
      checks++;
      if (ser_dout !== exp) begin
         errors++;
         $display("FAIL %s ser_dout actual=%b expected=%b", req, ser_dout, exp);
      end
   endtask

   initial begin
      wait_clk(200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      check_ch("R8 reset", '0);
      check_do("R7 reset", 1'b0);
      rst_n = 1'b1;
      wait_clk(4);

      // Table walk: R2 mapping, R5 blank, R6 fault, R9 resume
      for (int i = 0; i < 5; i++) begin
         logic [N-1:0] pat, exp;
         pat      = VEC[i][21:12];
         blank    = VEC[i][11];
         fault_ov = VEC[i][10];
         exp      = VEC[i][9:0];
         shift_word(pat);
         pulse_latch();
         check_ch("R2/R5/R6 gated", exp);
         check_do("R3 dout=ch9", pat[N-1]);
         blank    = 1'b0;
         fault_ov = 1'b0;
         wait_clk(4);
         check_ch("R9 resume", pat);
      end

      // R4: hold while latch low, then load
      shift_word(10'h0F0);
      pulse_latch();
      shift_word(10'h30F);
      check_ch("R4 hold", 10'h0F0);
      pulse_latch();
      check_ch("R4 load", 10'h30F);

      // R5/R9: blank then release restores the same pattern
      blank = 1'b1;
      wait_clk(4);
      check_ch("R5 blank", '0);
      blank = 1'b0;
      wait_clk(4);
      check_ch("R5 resume", 10'h30F);

      // R6: fault then clear
      fault_ov = 1'b1;
      wait_clk(4);
      check_ch("R6 fault", '0);
      fault_ov = 1'b0;
      wait_clk(4);
      check_ch("R6 resume", 10'h30F);

      // R1/R3: daisy chain read-out of previous contents
      shift_word(10'h2C6);
      check_do("R3 chain k0", 1'b1);
      for (int k = 1; k < N; k++) begin
         logic [N-1:0] a;
         a = 10'h2C6;
         shift_bit(1'b0);
         check_do("R1 R3 chain", a[N-1-k]);
      end
      check_ch("R4 no latch during chain", 10'h30F);

      // R7/R8: reset mid-run, zeros until full reload
      rst_n = 1'b0;
      wait_clk(2);
      check_ch("R8 reset clears latch", '0);
      rst_n = 1'b1;
      wait_clk(4);
      for (int k = 0; k < N - 1; k++) begin
         shift_bit(1'b1);
         check_do("R7 zeros before full", 1'b0);
      end
      shift_bit(1'b1);
      check_do("R7 first bit out", 1'b1);
      check_ch("R8 still off", '0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule